// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

The block controls one port of eight general-purpose pins and sits behind a simple 32-bit register bus: address, write strobe, write data, read strobe and read data. Each pin gets a 2-bit mode that selects one of four behaviours: push-pull driver, open-drain driver, digital input with the driver off, or analog. In analog mode both the driver and the digital input path are off. The port's output value lives in one data register. A write-protect mask freezes chosen pins against every kind of output write. Two write-only ports set or clear individual output bits without a read-modify-write.

Every pin's input can pass through a three-flop synchroniser, selected per pin. The selected input feeds both the input read path and the interrupt logic. The interrupt logic can detect a rising edge, a falling edge, either edge, a high level or a low level, again per pin. Detected events latch into pending flags, and software acknowledges them with write-one-to-clear. A single interrupt line is raised while any pending flag is also enabled. Pin-side outputs are the driven value, the driver enable and an open-drain marker for the pad.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Pin i's mode is the field at bits 2i+1:2i of register 0x00. The codes are:
  - 0: analog. Driver off (pin_oe=0, pin_out=0, pin_od=0).
  - 1: push-pull. pin_oe=1, pin_out equals the output data bit, pin_od=0.
  - 2: open-drain. pin_od=1, pin_out=0, and pin_oe=1 only while the output data bit is 0.
  - 3: input. Driver off (pin_oe=0, pin_out=0, pin_od=0).

  All modes reset to 0.
- R2: A write to 0x08 loads bits 7:0 into the output data register, which reads back at 0x08. The register resets to 0.
- R3: A pin whose bit is 1 in the write-protect register at 0x04 keeps its output data bit through writes to 0x08, 0x30 and 0x34.
- R4: Writing a 1 to bit i of 0x30 sets output bit i, and writing a 1 to bit i of 0x34 clears it. Bits written as 0 leave their outputs unchanged.
- R5: A read of 0x0C returns the pins' input values, with 0 for pins in analog mode. With the synchroniser off, the value is the pin level at the clock edge that samples the read strobe.
- R6: When bit i of 0x2C is 1, pin i's input passes through three flops before it reaches the read path and the interrupt logic. A change made just before edge 1 reads back at the read sampled at edge 4.
- R7: When bit i of the type register 0x20 is 0 (edge type), a polarity bit of 1 in 0x24 flags rising edges only, and a polarity bit of 0 flags falling edges only.
- R8: When bit i of 0x28 is 1, an edge-type pin flags both rising and falling edges, whatever its polarity bit says.
- R9: When bit i of 0x20 is 1 (level type), the flag is set on every cycle that the level matches the polarity bit, so an acknowledge during the active level has no lasting effect. When an acknowledge and a new event hit the same cycle, the flag stays set.
- R10: Pending flags are read at 0x14, and they set whether or not the pin is enabled in 0x10. Writing a 1 to a bit of 0x1C clears that flag. The irq output is high while any flag is 1 together with its enable bit.
- R11: Read data appears in the cycle after the read strobe. Unused bits, unmapped addresses and the write-only addresses 0x1C, 0x30 and 0x34 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 8 | Sampled pad input levels |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Driver enable for each pad |
| pin_od | output | 8 | Pad is in open-drain mode |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of functions can land in the same clock cycle.

The first pair is an acknowledge write to the pending flags and a new event on the same pin. The bench raises an either-edge pin in exactly the cycle that carries the acknowledge write, and it then expects the flag to read back as set. The same question arises for a level-type pin held at its active level: an acknowledge during the level must leave the flag set.

The second pair is a write to the output data and the write-protect mask. The bench drives plain, set and clear writes at protected pins and confirms through read-back that those bits never move.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_ANALOG    = 2'd0,
    PM_PUSHPULL  = 2'd1,
    PM_OPENDRAIN = 2'd2,
    PM_HIZ_IN    = 2'd3
  } pin_mode_e;

  localparam logic [7:0] ADR_PINMODE  = 8'h00;
  localparam logic [7:0] ADR_WRLOCK   = 8'h04;
  localparam logic [7:0] ADR_DOUT     = 8'h08;
  localparam logic [7:0] ADR_DIN      = 8'h0C;
  localparam logic [7:0] ADR_IRQ_EN   = 8'h10;
  localparam logic [7:0] ADR_IRQ_PEND = 8'h14;
  localparam logic [7:0] ADR_IRQ_ACK  = 8'h1C;
  localparam logic [7:0] ADR_IRQ_KIND = 8'h20;
  localparam logic [7:0] ADR_IRQ_POL  = 8'h24;
  localparam logic [7:0] ADR_IRQ_ANY  = 8'h28;
  localparam logic [7:0] ADR_SYNC_EN  = 8'h2C;
  localparam logic [7:0] ADR_BIT_SET  = 8'h30;
  localparam logic [7:0] ADR_BIT_CLR  = 8'h34;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] raw,
  input  logic [NPINS-1:0] sync_en,
  input  logic [NPINS-1:0] dig_en,
  output logic [NPINS-1:0] din
);

  logic [NPINS-1:0] stg [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[k] <= '0;
          else     stg[k] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[k] <= '0;
          else     stg[k] <= stg[k-1];
        end
      end
    end
  endgenerate

  assign din = ((sync_en & stg[STAGES-1]) | (~sync_en & raw)) & dig_en;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] din,
  input  logic [NPINS-1:0] kind,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] any,
  input  logic [NPINS-1:0] en,
  input  logic [NPINS-1:0] ack,
  output logic [NPINS-1:0] flag,
  output logic             irq
);

  logic [NPINS-1:0] prev_q, flag_q, hit;
  logic [NPINS-1:0] rise, fall, edge_hit, lvl_hit;
  logic             armed_q;

  assign rise     = din & ~prev_q;
  assign fall     = ~din & prev_q;
  assign edge_hit = (any & (rise | fall)) | (~any & ((pol & rise) | (~pol & fall)));
  assign lvl_hit  = ~(din ^ pol);
  assign hit      = (kind & lvl_hit) | (~kind & edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      flag_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= din;
      flag_q  <= (flag_q & ~ack) | hit;
      armed_q <= 1'b1;
    end
  end

  assign flag = flag_q;
  assign irq  = |(flag_q & en);

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ((flag_q & $past(hit)) == $past(hit))); // R9
  AST_ACK_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ((flag_q & $past(ack & ~hit)) == '0)); // R10

endmodule

// File: rtl/gpio_out_drive.sv
module gpio_out_drive
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic [2*NPINS-1:0] mode,
  input  logic [NPINS-1:0]   dout,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_od
);

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      pin_out[i] = 1'b0;
      pin_oe[i]  = 1'b0;
      pin_od[i]  = 1'b0;
      case (pin_mode_e'(mode[2*i +: 2]))
        PM_PUSHPULL: begin
          pin_oe[i]  = 1'b1;
          pin_out[i] = dout[i];
        end
        PM_OPENDRAIN: begin
          pin_od[i] = 1'b1;
          pin_oe[i] = ~dout[i];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_od,
  output logic              irq
);

  localparam int MODE_W = 2 * NPINS;

  logic [MODE_W-1:0] mode_q;
  logic [NPINS-1:0]  lock_q, dout_q, en_q, kind_q, pol_q, any_q, sync_q;
  logic [NPINS-1:0]  wlo, free_m, ack_m, dig_en, din, flag;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              set_wr, wo_sel, armed_q;
  logic              unused_wdata_hi;

  function automatic logic sel(input logic [7:0] adr);
    return bus_addr == ADDR_W'(adr);
  endfunction

  assign wlo             = bus_wdata[NPINS-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:MODE_W];
  assign free_m          = ~lock_q;
  assign ack_m           = (bus_wr && sel(ADR_IRQ_ACK)) ? wlo : '0;
  assign set_wr          = bus_wr && sel(ADR_BIT_SET);
  assign wo_sel          = sel(ADR_IRQ_ACK) || sel(ADR_BIT_SET) || sel(ADR_BIT_CLR);

  // Configuration and output data registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      lock_q <= '0;
      dout_q <= '0;
      en_q   <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      sync_q <= '0;
    end else if (bus_wr) begin
      if (sel(ADR_PINMODE))  mode_q <= bus_wdata[MODE_W-1:0];
      if (sel(ADR_WRLOCK))   lock_q <= wlo;
      if (sel(ADR_DOUT))     dout_q <= (dout_q & lock_q) | (wlo & free_m);
      if (sel(ADR_BIT_SET))  dout_q <= dout_q | (wlo & free_m);
      if (sel(ADR_BIT_CLR))  dout_q <= dout_q & ~(wlo & free_m);
      if (sel(ADR_IRQ_EN))   en_q   <= wlo;
      if (sel(ADR_IRQ_KIND)) kind_q <= wlo;
      if (sel(ADR_IRQ_POL))  pol_q  <= wlo;
      if (sel(ADR_IRQ_ANY))  any_q  <= wlo;
      if (sel(ADR_SYNC_EN))  sync_q <= wlo;
    end
  end

  generate
    for (genvar gi = 0; gi < NPINS; gi++) begin : g_dig
      assign dig_en[gi] = pin_mode_e'(mode_q[2*gi +: 2]) != PM_ANALOG;
    end
  endgenerate

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .raw     (pin_in),
    .sync_en (sync_q),
    .dig_en  (dig_en),
    .din     (din)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .kind (kind_q),
    .pol  (pol_q),
    .any  (any_q),
    .en   (en_q),
    .ack  (ack_m),
    .flag (flag),
    .irq  (irq)
  );

  gpio_out_drive #(.NPINS(NPINS)) u_drive (
    .mode    (mode_q),
    .dout    (dout_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_od  (pin_od)
  );

  // Read path
  always_comb begin
    rd_mux = '0;
    if      (sel(ADR_PINMODE))  rd_mux[MODE_W-1:0] = mode_q;
    else if (sel(ADR_WRLOCK))   rd_mux[NPINS-1:0]  = lock_q;
    else if (sel(ADR_DOUT))     rd_mux[NPINS-1:0]  = dout_q;
    else if (sel(ADR_DIN))      rd_mux[NPINS-1:0]  = din;
    else if (sel(ADR_IRQ_EN))   rd_mux[NPINS-1:0]  = en_q;
    else if (sel(ADR_IRQ_PEND)) rd_mux[NPINS-1:0]  = flag;
    else if (sel(ADR_IRQ_KIND)) rd_mux[NPINS-1:0]  = kind_q;
    else if (sel(ADR_IRQ_POL))  rd_mux[NPINS-1:0]  = pol_q;
    else if (sel(ADR_IRQ_ANY))  rd_mux[NPINS-1:0]  = any_q;
    else if (sel(ADR_SYNC_EN))  rd_mux[NPINS-1:0]  = sync_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      armed_q <= 1'b1;
    end
  end

  assign bus_rdata = rdata_q;

  AST_LOCK_FREEZES_DOUT: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ((dout_q & $past(lock_q)) == ($past(dout_q) & $past(lock_q)))); // R3
  AST_SET_RAISES_BITS: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(set_wr)) |-> ((dout_q & $past(wlo & free_m)) == $past(wlo & free_m))); // R4
  AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(bus_rd && wo_sel)) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, pin_od;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
    .irq(irq)
  );

  // Monitor: pops the expected read item when read data is valid
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s read act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: issues a read and pushes the expected item
  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();

    // Reset state
    check("R1 reset oe", {24'h0, pin_oe}, 32'h0);
    check("R10 reset irq", {31'h0, irq}, 32'h0);
    bus_read(8'h08, 32'h0, "R2 reset dout");

    // Modes: p0,p1 push-pull; p2,p3 open-drain; p4 analog; p5..p7 input
    bus_write(8'h00, 32'h0000FCA5);
    check("R1 oe dout=0", {24'h0, pin_oe}, 32'h0F);
    check("R1 od", {24'h0, pin_od}, 32'h0C);
    check("R1 out dout=0", {24'h0, pin_out}, 32'h00);
    bus_read(8'h00, 32'h0000FCA5, "R11 mode readback");

    bus_write(8'h08, 32'hFFFF_FFFF);
    check("R1 oe dout=FF", {24'h0, pin_oe}, 32'h03);
    check("R1 out dout=FF", {24'h0, pin_out}, 32'h03);
    bus_read(8'h08, 32'hFF, "R2 dout readback");

    bus_write(8'h34, 32'h05);
    check("R4 oe after clear", {24'h0, pin_oe}, 32'h07);
    check("R4 out after clear", {24'h0, pin_out}, 32'h02);
    bus_read(8'h08, 32'hFA, "R4 clear result");
    bus_read(8'h34, 32'h0, "R11 write-only reads zero");

    // Write protect on p0..p3
    bus_write(8'h04, 32'h0F);
    bus_read(8'h04, 32'h0F, "R3 lock readback");
    bus_write(8'h08, 32'h00);
    bus_read(8'h08, 32'h0A, "R3 plain write masked");
    bus_write(8'h30, 32'hFF);
    bus_read(8'h08, 32'hFA, "R3 set masked");
    bus_write(8'h34, 32'hFF);
    bus_read(8'h08, 32'h0A, "R3 clear masked");
    bus_write(8'h04, 32'h00);
    bus_write(8'h30, 32'h01);
    bus_read(8'h08, 32'h0B, "R4 set single bit");

    // Raw input read, analog pin reads 0
    pin_in = 8'hFF;
    bus_read(8'h0C, 32'hEF, "R5 raw input");
    bus_read(8'h18, 32'h0, "R11 unmapped address");
    pin_in = 8'h00;
    tick();
    bus_write(8'h1C, 32'hFF);
    bus_read(8'h14, 32'h0, "R10 flags cleared");

    // Rising edge on p5
    bus_write(8'h24, 32'h20);
    pin_in = 8'h20; tick();
    bus_read(8'h14, 32'h20, "R7 rising flagged");
    check("R10 irq off while disabled", {31'h0, irq}, 32'h0);
    bus_write(8'h10, 32'h20);
    check("R10 irq on when enabled", {31'h0, irq}, 32'h1);
    bus_write(8'h1C, 32'h20);
    check("R10 irq drops on ack", {31'h0, irq}, 32'h0);
    bus_read(8'h14, 32'h0, "R10 ack clears flag");
    pin_in = 8'h00; tick();
    bus_read(8'h14, 32'h0, "R7 falling ignored on rising pin");

    // Falling edge on p6
    pin_in = 8'h40; tick();
    bus_read(8'h14, 32'h0, "R7 rising ignored on falling pin");
    pin_in = 8'h00; tick();
    bus_read(8'h14, 32'h40, "R7 falling flagged");
    bus_write(8'h1C, 32'hFF);

    // Both edges on p7 (polarity says falling)
    bus_write(8'h28, 32'h80);
    pin_in = 8'h80; tick();
    bus_read(8'h14, 32'h80, "R8 rising flagged by both-edge");
    bus_write(8'h1C, 32'hFF);
    pin_in = 8'h00; tick();
    bus_read(8'h14, 32'h80, "R8 falling flagged by both-edge");
    bus_write(8'h1C, 32'hFF);

    // High level on p6
    bus_write(8'h24, 32'h60);
    bus_write(8'h20, 32'h40);
    bus_write(8'h1C, 32'hFF);
    pin_in = 8'h40; tick();
    bus_read(8'h14, 32'h40, "R9 level flagged");
    bus_write(8'h1C, 32'h40);
    bus_read(8'h14, 32'h40, "R9 level re-flags after ack");
    pin_in = 8'h00; tick();
    bus_write(8'h1C, 32'hFF);
    bus_read(8'h14, 32'h0, "R9 inactive level stays clear");

    // Ack and new edge in the same cycle on p7
    pin_in = 8'h80;
    bus_write(8'h1C, 32'h80);
    bus_read(8'h14, 32'h80, "R9 event wins over ack");
    bus_write(8'h1C, 32'h80);
    bus_read(8'h14, 32'h0, "R10 ack alone clears");

    // Synchroniser on p1
    bus_write(8'h2C, 32'h02);
    tick();
    pin_in = 8'h82;
    bus_read(8'h0C, 32'h80, "R6 sync edge1");
    bus_read(8'h0C, 32'h80, "R6 sync edge2");
    bus_read(8'h0C, 32'h80, "R6 sync edge3");
    bus_read(8'h0C, 32'h82, "R6 sync edge4");
    bus_read(8'h2C, 32'h02, "R6 sync readback");

    tick(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule